// File: doc/BRIEF.md
# Per-Stream Command Scheduler with Three Execution Engines

This block sits between a host-side command queue and three execution engines: an inbound copy engine, a compute engine and an outbound copy engine. The host tags every command with a stream number. Each stream keeps its own small command queue, and its commands leave it strictly one at a time. A stream's next command cannot start until the previous one has finished. Commands from different streams may run at the same time, with at most one command on each engine. When several streams want the same idle engine, a rotating arbiter chooses one of them.

A fourth command kind marks a point in a stream. It completes once everything queued ahead of it in that stream is done. At that moment it stores the value of a free-running 32-bit cycle counter under its marker number. The host selects two marker numbers on query inputs. One cycle later it reads whether the first marker has completed, and the time between the two markers whenever both have completed.

The engines are modelled as responders that stay busy for the number of cycles carried in the command. Each stream queue reports when it is full. A command written into a full queue is lost, and the loss is recorded in a sticky per-stream flag.

Top module: `cmd_stream_sched`

## Requirements
- R1: After reset, no engine is busy, no queue is full, no overflow flag is set, no marker reads as completed, and the time-valid output is low with the time output at 0.
- R2: A copy-in (opcode 0), kernel (opcode 1) or copy-out (opcode 2) command with duration D, written to an idle and empty stream, makes its engine busy from the clock edge after the write. The engine stays busy for max(D,1) cycles and reports the stream number as its owner.
- R3: Each of the three streams queues 4 commands. When 4 are waiting, the stream's full flag is high. A further write to that stream is dropped and sets that stream's overflow bit, which stays set after the queue drains.
- R4: Commands of one stream run in write order. A second command of a stream never runs at the same time as the first, even when it targets a different engine.
- R5: Commands of different streams that target different engines run at the same time.
- R6: When several streams wait for the same idle engine, a round-robin arbiter grants it. The stream after the last granted one has first priority, whatever the order of arrival.
- R7: A marker command (opcode 3, low 3 bits of the argument giving the marker number) completes only after all earlier commands of its stream have finished. It completes in the cycle after that, and a stream holding only markers completes them one per cycle.
- R8: For query markers A and B, the time output is stamp(B) minus stamp(A) modulo 2^32, with the valid flag high, one cycle after both have completed. Otherwise the valid flag is low and the time output is 0.
- R9: Writing a marker command clears the completed state of that marker number until the new marker completes.
- R10: A command with stream number 3 is ignored. It starts no engine, fills no queue and sets no overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 2 | Opcode: 0 copy-in, 1 kernel, 2 copy-out, 3 marker |
| cmd_stream | input | 2 | Stream number (0 to 2 valid) |
| cmd_arg | input | 16 | Duration in cycles, or marker number in the low bits |
| stream_full | output | 3 | Per-stream queue full |
| overflow | output | 3 | Per-stream sticky dropped-write flag |
| eng_busy | output | 3 | Busy per engine, bit index equals opcode |
| eng_stream | output | 6 | Owning stream per engine, 2 bits each, engine 0 lowest |
| q_mark_a | input | 3 | Start marker for queries |
| q_mark_b | input | 3 | End marker for the time query |
| mark_a_done | output | 1 | Marker A has completed |
| span_valid | output | 1 | Both markers completed; span is valid |
| span | output | 32 | stamp(B) minus stamp(A) |

## Verification
A command written at edge k reaches its queue head at that edge. An idle engine takes it at edge k+1, and it holds the engine for max(D,1) cycles. The stream is released at the edge where the engine drops busy, so the stream's next command starts one edge later. Markers behave the same way: a marker behind a command of duration D, itself behind a marker, is stamped D+2 cycles after that first marker. The query outputs lag their inputs and the marker table by one edge. The bench drives on falling edges and samples on falling edges at exactly these offsets. It counts busy cycles from the first falling edge after the grant edge.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;
  localparam int ARG_W = 16;
  localparam int SID_W = 2;

  typedef enum logic [1:0] {
    OP_COPY_IN  = 2'd0,
    OP_KERNEL   = 2'd1,
    OP_COPY_OUT = 2'd2,
    OP_MARK     = 2'd3
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [ARG_W-1:0] arg;
  } cmd_t;
endpackage

// File: rtl/sched_stream_fifo.sv
module sched_stream_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/sched_rr_arb.sv
module sched_rr_arb #(
  parameter int N = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take && any) ptr <= (int'(idx) == N-1) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/sched_engine.sv
module sched_engine #(
  parameter int DUR_W = 16,
  parameter int SID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DUR_W-1:0] dur,
  input  logic [SID_W-1:0] sid,
  output logic             busy,
  output logic [SID_W-1:0] owner,
  output logic             fin
);
  logic [DUR_W-1:0] left;

  assign fin = busy && (left == DUR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      left  <= '0;
      owner <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      left  <= (dur == '0) ? DUR_W'(1) : dur;
      owner <= sid;
    end else if (busy) begin
      if (fin) busy <= 1'b0;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/cmd_stream_sched.sv
module cmd_stream_sched
  import cmd_sched_pkg::*;
#(
  parameter int NSTREAM = 3,
  parameter int QDEPTH  = 4,
  parameter int NMARK   = 8,
  parameter int TS_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [SID_W-1:0]            cmd_stream,
  input  logic [ARG_W-1:0]            cmd_arg,
  output logic [NSTREAM-1:0]          stream_full,
  output logic [NSTREAM-1:0]          overflow,
  output logic [2:0]                  eng_busy,
  output logic [3*SID_W-1:0]          eng_stream,
  input  logic [$clog2(NMARK)-1:0]    q_mark_a,
  input  logic [$clog2(NMARK)-1:0]    q_mark_b,
  output logic                        mark_a_done,
  output logic                        span_valid,
  output logic [TS_W-1:0]             span
);
  localparam int NENG = 3;
  localparam int MW   = $clog2(NMARK);
  localparam int IW   = $clog2(NSTREAM);
  localparam int CW   = $bits(cmd_t);

  cmd_t               hd [NSTREAM];
  logic [NSTREAM-1:0] q_empty, q_full, push, pop, ready, is_mark, in_flight;

  // per-stream queues
  for (genvar s = 0; s < NSTREAM; s++) begin : g_q
    logic [CW-1:0] dout;
    assign push[s] = cmd_valid && (cmd_stream == SID_W'(s)) && !q_full[s];
    sched_stream_fifo #(.W(CW), .DEPTH(QDEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push[s]), .pop(pop[s]),
      .din({cmd_op, cmd_arg}), .dout(dout),
      .empty(q_empty[s]), .full(q_full[s])
    );
    assign hd[s]      = cmd_t'(dout);
    assign ready[s]   = !q_empty[s] && !in_flight[s];
    assign is_mark[s] = ready[s] && (hd[s].op == OP_MARK);
  end

  // engines with their arbiters; engine index equals opcode
  logic [NENG-1:0]    e_start, e_fin, e_any;
  logic [IW-1:0]      e_idx   [NENG];
  logic [SID_W-1:0]   e_owner [NENG];
  logic [NSTREAM-1:0] e_req   [NENG];

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    for (genvar s = 0; s < NSTREAM; s++) begin : g_req
      assign e_req[e][s] = ready[s] && (hd[s].op == op_e'(e));
    end
    sched_rr_arb #(.N(NSTREAM)) u_arb (
      .clk(clk), .rst(rst), .req(e_req[e]), .take(!eng_busy[e]),
      .any(e_any[e]), .idx(e_idx[e])
    );
    assign e_start[e] = e_any[e] && !eng_busy[e];
    sched_engine #(.DUR_W(ARG_W), .SID_W(SID_W)) u_eng (
      .clk(clk), .rst(rst), .start(e_start[e]),
      .dur(hd[e_idx[e]].arg), .sid(SID_W'(e_idx[e])),
      .busy(eng_busy[e]), .owner(e_owner[e]), .fin(e_fin[e])
    );
    assign eng_stream[e*SID_W +: SID_W] = e_owner[e];
  end

  always_comb begin
    pop = is_mark;
    for (int e = 0; e < NENG; e++) begin
      if (e_start[e]) pop[e_idx[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_flight <= '0;
      overflow  <= '0;
    end else begin
      for (int e = 0; e < NENG; e++) begin
        if (e_fin[e])   in_flight[e_owner[e]] <= 1'b0;
        if (e_start[e]) in_flight[e_idx[e]]   <= 1'b1;
      end
      for (int s = 0; s < NSTREAM; s++) begin
        if (cmd_valid && cmd_stream == SID_W'(s) && q_full[s]) overflow[s] <= 1'b1;
      end
    end
  end

  assign stream_full = q_full;

  // timestamps and marker table
  logic [TS_W-1:0]  ts;
  logic [TS_W-1:0]  stamp [NMARK];
  logic [NMARK-1:0] done;
  logic             enq_mark;

  assign enq_mark = cmd_valid && (cmd_op == OP_MARK) && (32'(cmd_stream) < NSTREAM)
                    && !q_full[cmd_stream[IW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= '0;
      for (int m = 0; m < NMARK; m++) stamp[m] <= '0;
    end else begin
      for (int s = 0; s < NSTREAM; s++) begin
        if (is_mark[s]) begin
          stamp[hd[s].arg[MW-1:0]] <= ts;
          done[hd[s].arg[MW-1:0]]  <= 1'b1;
        end
      end
      if (enq_mark) done[cmd_arg[MW-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_a_done <= 1'b0;
      span_valid  <= 1'b0;
      span        <= '0;
    end else begin
      mark_a_done <= done[q_mark_a];
      span_valid  <= done[q_mark_a] && done[q_mark_b];
      span        <= (done[q_mark_a] && done[q_mark_b]) ? stamp[q_mark_b] - stamp[q_mark_a] : '0;
    end
  end
endmodule

// File: rtl/cmd_stream_sched_checker.sv
module cmd_stream_sched_checker #(
  parameter int NSTREAM = 3,
  parameter int TS_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [1:0]         cmd_stream,
  input logic [NSTREAM-1:0] stream_full,
  input logic [NSTREAM-1:0] overflow,
  input logic [2:0]         eng_busy,
  input logic [5:0]         eng_stream,
  input logic               span_valid,
  input logic [TS_W-1:0]    span
);
  // R1: reset clears the visible state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (eng_busy == '0 && overflow == '0 && !span_valid && stream_full == '0));

  // R2: owner holds while an engine stays busy
  for (genvar e = 0; e < 3; e++) begin : g_own
    p_owner_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (eng_busy[e] && $past(eng_busy[e])) |-> $stable(eng_stream[e*2 +: 2]));
  end

  // R3: overflow bits never clear, and a write into a full queue sets them
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((overflow & $past(overflow)) == $past(overflow)));
  for (genvar s = 0; s < NSTREAM; s++) begin : g_ovf
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_stream == 2'(s) && stream_full[s]) |=> overflow[s]);
  end

  // R4: two busy engines never serve the same stream
  for (genvar i = 0; i < 3; i++) begin : g_i
    for (genvar j = i + 1; j < 3; j++) begin : g_j
      p_stream_serial_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_busy[i] && eng_busy[j]) |-> (eng_stream[i*2 +: 2] != eng_stream[j*2 +: 2]));
    end
  end

  // R8: the time output is zero whenever it is not valid
  p_span_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !span_valid |-> (span == '0));
endmodule

bind cmd_stream_sched cmd_stream_sched_checker #(.NSTREAM(NSTREAM), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_stream(cmd_stream),
  .stream_full(stream_full), .overflow(overflow), .eng_busy(eng_busy),
  .eng_stream(eng_stream), .span_valid(span_valid), .span(span)
);

// File: tb/cmd_stream_sched_bench.sv
`timescale 1ns/1ps
module cmd_stream_sched_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_stream = '0;
  logic [15:0] cmd_arg = '0;
  logic [2:0]  stream_full, overflow, eng_busy;
  logic [5:0]  eng_stream;
  logic [2:0]  q_mark_a = '0, q_mark_b = '0;
  logic        mark_a_done, span_valid;
  logic [31:0] span;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmd_stream_sched u_cmd_stream_sched (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_stream(cmd_stream), .cmd_arg(cmd_arg), .stream_full(stream_full),
    .overflow(overflow), .eng_busy(eng_busy), .eng_stream(eng_stream),
    .q_mark_a(q_mark_a), .q_mark_b(q_mark_b), .mark_a_done(mark_a_done),
    .span_valid(span_valid), .span(span)
  );

  // {op, stream, duration, expected busy cycles}
  localparam logic [27:0] VEC [6] = '{
    {2'd0, 2'd0, 16'd3, 8'd3},
    {2'd1, 2'd1, 16'd5, 8'd5},
    {2'd2, 2'd2, 16'd1, 8'd1},
    {2'd1, 2'd0, 16'd0, 8'd1},
    {2'd0, 2'd2, 16'd7, 8'd7},
    {2'd2, 2'd1, 16'd2, 8'd2}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] sid, input logic [15:0] arg);
    cmd_valid = 1'b1; cmd_op = op; cmd_stream = sid; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk(eng_busy == 0 && stream_full == 0 && overflow == 0, "R1 engines/queues idle",
        {eng_busy, stream_full, overflow}, 0);
    chk(!mark_a_done && !span_valid && span == 0, "R1 marker outputs clear",
        {mark_a_done, span_valid, span[29:0]}, 0);

    // R2: table of isolated commands
    for (int i = 0; i < 6; i++) begin
      logic [1:0] op, sid;
      logic [15:0] dur;
      int expc, n;
      {op, sid, dur} = VEC[i][27:8];
      expc = int'(VEC[i][7:0]);
      send(op, sid, dur);
      chk(eng_busy[op] == 1'b0, "R2 not busy before grant edge", eng_busy[op], 0);
      @(negedge clk);
      chk(eng_stream[op*2 +: 2] == sid, "R2 owner", eng_stream[op*2 +: 2], sid);
      n = 0;
      while (eng_busy[op] && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == expc, "R2 busy length", n, expc);
      idle(2);
    end

    // R4: same stream, two engines, strictly serial
    do_reset();
    send(2'd0, 2'd0, 16'd4);
    send(2'd1, 2'd0, 16'd3);
    begin
      int both, nc, nk;
      both = 0; nc = 0; nk = 0;
      for (int c = 0; c < 16; c++) begin
        if (eng_busy[0] && eng_busy[1]) both++;
        if (eng_busy[0]) nc++;
        if (eng_busy[1]) nk++;
        @(negedge clk);
      end
      chk(both == 0, "R4 no overlap within stream", both, 0);
      chk(nc == 4 && nk == 3, "R4 both commands ran", nc * 10 + nk, 43);
    end

    // R5: different streams overlap
    do_reset();
    send(2'd0, 2'd0, 16'd6);
    send(2'd1, 2'd1, 16'd6);
    @(negedge clk);
    chk(eng_busy[1:0] == 2'b11, "R5 copy-in and kernel concurrent", eng_busy[1:0], 3);
    idle(10);

    // R6: round robin on the kernel engine
    do_reset();
    send(2'd1, 2'd0, 16'd10);
    send(2'd1, 2'd2, 16'd2);
    send(2'd1, 2'd1, 16'd2);
    begin
      logic prev;
      int nr;
      logic [1:0] seq [2];
      prev = 1'b1; nr = 0; seq[0] = 0; seq[1] = 0;
      for (int c = 0; c < 30; c++) begin
        if (eng_busy[1] && !prev && nr < 2) begin
          seq[nr] = eng_stream[3:2];
          nr++;
        end
        prev = eng_busy[1];
        @(negedge clk);
      end
      chk(nr == 2 && seq[0] == 2'd1, "R6 first grant after rotation", seq[0], 1);
      chk(seq[1] == 2'd2, "R6 second grant", seq[1], 2);
    end

    // R7/R8: marker, copy, marker
    do_reset();
    q_mark_a = 3'd1; q_mark_b = 3'd2;
    send(2'd3, 2'd0, 16'd1);
    send(2'd0, 2'd0, 16'd5);
    send(2'd3, 2'd0, 16'd2);
    chk(!span_valid && span == 0, "R8 not ready while second marker pending", span, 0);
    q_mark_a = 3'd2;
    @(negedge clk);
    chk(!mark_a_done, "R7 marker waits behind running copy", mark_a_done, 0);
    q_mark_a = 3'd1;
    idle(8);
    chk(mark_a_done, "R7 first marker completed", mark_a_done, 1);
    chk(span_valid && span == 32'd7, "R8 elapsed equals D+2", span, 7);
    q_mark_b = 3'd5;
    idle(2);
    chk(!span_valid && span == 0, "R8 unrecorded end marker not ready", span, 0);

    // R9: re-enqueued marker clears its done state
    q_mark_a = 3'd2;
    idle(1);
    chk(mark_a_done, "R9 marker 2 done before reuse", mark_a_done, 1);
    send(2'd2, 2'd1, 16'd6);
    send(2'd3, 2'd1, 16'd2);
    @(negedge clk);
    chk(!mark_a_done, "R9 marker 2 cleared on write", mark_a_done, 0);
    idle(10);
    chk(mark_a_done, "R9 marker 2 completes again", mark_a_done, 1);

    // R3: fill stream 2 and overflow it
    do_reset();
    send(2'd0, 2'd2, 16'd20);
    for (int i = 0; i < 4; i++) send(2'd1, 2'd2, 16'd1);
    chk(stream_full == 3'b100, "R3 full flag", stream_full, 4);
    chk(overflow == 3'b000, "R3 no overflow yet", overflow, 0);
    send(2'd1, 2'd2, 16'd1);
    chk(overflow == 3'b100, "R3 dropped write flagged", overflow, 4);
    idle(40);
    chk(stream_full == 0 && overflow == 3'b100, "R3 overflow sticky after drain",
        {stream_full, overflow}, 4);

    // R10: stream 3 ignored
    do_reset();
    send(2'd0, 2'd3, 16'd5);
    idle(2);
    chk(eng_busy == 0 && stream_full == 0 && overflow == 0, "R10 stream 3 ignored",
        {eng_busy, stream_full, overflow}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule